// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called the A side and the B side. In each direction, the receiving side gets one of two values. One is the live value on the other side, passed through with no register. The other is a snapshot of that value held in a capture register. Each direction has its own capture register and its own capture clock, and the two clocks need not be related. Each bidirectional pin group appears as a separate input vector, output vector and output-enable vector. Pad buffers are left to the surrounding chip.

Three inputs decide which side drives: an active-low output enable, a direction select, and one live/stored select per direction. The two capture registers load on every rising edge of their own clock, whatever the enable and direction settings. Software can therefore capture a bus value while both sides are isolated and replay it later.

Top module: `dual_path_xcvr`

## Requirements
- R1: The A-to-B capture register loads `aIn` on every rising edge of `clkAb`, whatever the values of `outEnN`, `dirSel` and the selects.
- R2: The B-to-A capture register loads `bIn` on every rising edge of `clkBa`. This happens independently of `clkAb` and of every control input.
- R3: While `outEnN` is 1, both `aOe` and `bOe` are all zeros. Both registers keep loading on their own clocks during this time.
- R4: With `outEnN` 0 and `dirSel` 1, `bOe` is all ones and `aOe` is all zeros. With `outEnN` 0 and `dirSel` 0, `aOe` is all ones and `bOe` is all zeros.
- R5: While the B side drives and `selAb` is 0, `bOut` equals the current `aIn`, combinationally.
- R6: While the B side drives and `selAb` is 1, `bOut` equals the A-to-B capture register.
- R7: While the A side drives and `selBa` is 0, `aOut` equals the current `bIn`, combinationally.
- R8: While the A side drives and `selBa` is 1, `aOut` equals the B-to-A capture register.
- R9: `rst` is active high and synchronous. Each register samples it on its own clock and is cleared to zero. While `rst` is 1, both output-enable vectors are all zeros.
- R10: Each output-enable vector is either all ones or all zeros. `aOe` and `bOe` are never nonzero together.
- R11: The output vector of a side that is not driving is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkAb | input | 1 | Capture clock of the A-to-B register |
| clkBa | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high reset; also forces both enables off |
| outEnN | input | 1 | Active-low output enable |
| dirSel | input | 1 | 1: B side drives, 0: A side drives |
| selAb | input | 1 | B-side source: 0 live A input, 1 stored A-to-B value |
| selBa | input | 1 | A-side source: 0 live B input, 1 stored B-to-A value |
| aIn | input | WIDTH | Value seen on the A pins |
| bIn | input | WIDTH | Value seen on the B pins |
| aOut | output | WIDTH | Value driven toward the A pins |
| aOe | output | WIDTH | Per-bit drive enable for the A pins |
| bOut | output | WIDTH | Value driven toward the B pins |
| bOe | output | WIDTH | Per-bit drive enable for the B pins |

## Verification
The bench builds the block with the default WIDTH of 8. At this width random data covers every bit position, and the directed patterns 8'hA5 and 8'h3C make the live and stored paths clearly different.

The two clocks run at 50 MHz and about 38.5 MHz. Their edges therefore land in every phase relation to each other, so each register loads under every combination of enable, direction and select. This includes loads during isolation that are read back later.

Random short reset pulses land on edges of one clock but not the other. This covers the case where only one of the two registers has seen the reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic driveA;       // A side is the driving side
    logic driveB;       // B side is the driving side
    logic useStoredAb;  // B side shows the stored A-to-B value
    logic useStoredBa;  // A side shows the stored B-to-A value
  } xcvrStrobe_t;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  // Loads on every edge; not gated by any control input
  always_ff @(posedge clk) begin
    if (rst) qOut <= '0;
    else     qOut <= dIn;
  end

endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        rst,
  input  logic        outEnN,
  input  logic        dirSel,
  input  logic        selAb,
  input  logic        selBa,
  output xcvrStrobe_t strobe
);

  logic enabled;

  always_comb begin
    enabled            = !outEnN && !rst;
    strobe.driveB      = enabled && dirSel;
    strobe.driveA      = enabled && !dirSel;
    strobe.useStoredAb = selAb;
    strobe.useStoredBa = selBa;
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAb,
  input  logic             clkBa,
  input  logic             rst,
  input  xcvrStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);

  logic [WIDTH-1:0] heldAb;
  logic [WIDTH-1:0] heldBa;
  logic [WIDTH-1:0] srcAb;
  logic [WIDTH-1:0] srcBa;

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_regAb (
    .clk(clkAb), .rst(rst), .dIn(aIn), .qOut(heldAb)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_regBa (
    .clk(clkBa), .rst(rst), .dIn(bIn), .qOut(heldBa)
  );

  always_comb begin
    srcAb = strobe.useStoredAb ? heldAb : aIn;
    srcBa = strobe.useStoredBa ? heldBa : bIn;
    bOut  = strobe.driveB ? srcAb : '0;
    aOut  = strobe.driveA ? srcBa : '0;
    bOe   = {WIDTH{strobe.driveB}};
    aOe   = {WIDTH{strobe.driveA}};
  end

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAb,
  input  logic             clkBa,
  input  logic             rst,
  input  logic             outEnN,
  input  logic             dirSel,
  input  logic             selAb,
  input  logic             selBa,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);

  xcvrStrobe_t strobe;

  xcvr_ctrl u_ctrl (
    .rst(rst), .outEnN(outEnN), .dirSel(dirSel),
    .selAb(selAb), .selBa(selBa), .strobe(strobe)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clkAb(clkAb), .clkBa(clkBa), .rst(rst), .strobe(strobe),
    .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clkAb,
  input logic             clkBa,
  input logic             rst,
  input logic             outEnN,
  input logic             dirSel,
  input logic             selAb,
  input logic             selBa,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] aOe,
  input logic [WIDTH-1:0] bOut,
  input logic [WIDTH-1:0] bOe
);

  // R10
  oe_exclusive_chk: assert property (@(posedge clkAb) disable iff (rst)
    !((|aOe) && (|bOe)));

  // R10
  oe_uniform_chk: assert property (@(posedge clkBa) disable iff (rst)
    ((aOe == '0) || (aOe == '1)) && ((bOe == '0) || (bOe == '1)));

  // R3
  isolate_chk: assert property (@(posedge clkAb) disable iff (rst)
    outEnN |-> (aOe == '0 && bOe == '0));

  // R9
  reset_quiet_chk: assert property (@(posedge clkAb)
    rst |-> (aOe == '0 && bOe == '0));

  // R5
  live_ab_chk: assert property (@(posedge clkAb) disable iff (rst)
    (!outEnN && dirSel && !selAb) |-> (bOut == aIn));

  // R6
  stored_ab_chk: assert property (@(posedge clkAb) disable iff (rst)
    (!outEnN && dirSel && selAb && !$past(rst)) |-> (bOut == $past(aIn)));

  // R8
  stored_ba_chk: assert property (@(posedge clkBa) disable iff (rst)
    (!outEnN && !dirSel && selBa && !$past(rst)) |-> (aOut == $past(bIn)));

endmodule

bind dual_path_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_path_xcvr_bench.sv
`timescale 1ns/100ps
module dual_path_xcvr_bench;

  localparam int W = 8;

  logic clkAb = 1'b0;
  logic clkBa = 1'b0;
  logic rst = 1'b1;
  logic outEnN = 1'b1;
  logic dirSel = 1'b0;
  logic selAb = 1'b0;
  logic selBa = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic [W-1:0] aOut, aOe, bOut, bOe;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // Reference copies of the two capture registers
  logic [W-1:0] refAb = '0;
  logic [W-1:0] refBa = '0;

  always #10 clkAb = ~clkAb;  // 50 MHz
  always #13 clkBa = ~clkBa;  // unrelated second clock

  always @(posedge clkAb) refAb <= rst ? '0 : aIn;  // R1, R9
  always @(posedge clkBa) refBa <= rst ? '0 : bIn;  // R2, R9

  dual_path_xcvr #(.WIDTH(W)) u_dual_path_xcvr (
    .clkAb(clkAb), .clkBa(clkBa), .rst(rst), .outEnN(outEnN),
    .dirSel(dirSel), .selAb(selAb), .selBa(selBa),
    .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  function automatic logic expDriveB();
    return !rst && !outEnN && dirSel;
  endfunction

  function automatic logic expDriveA();
    return !rst && !outEnN && !dirSel;
  endfunction

  function automatic logic [W-1:0] expBOut();
    if (!expDriveB()) return '0;
    return selAb ? refAb : aIn;
  endfunction

  function automatic logic [W-1:0] expAOut();
    if (!expDriveA()) return '0;
    return selBa ? refBa : bIn;
  endfunction

  task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic checkAll();
    string oeTag;
    oeTag = rst ? "R9" : (outEnN ? "R3" : "R4");
    cmp({oeTag, "/R10 aOe"}, aOe, {W{expDriveA()}});
    cmp({oeTag, "/R10 bOe"}, bOe, {W{expDriveB()}});
    if (!expDriveB())  cmp("R11 bOut idle", bOut, expBOut());
    else if (selAb)    cmp("R6/R1 bOut stored", bOut, expBOut());
    else               cmp("R5 bOut live", bOut, expBOut());
    if (!expDriveA())  cmp("R11 aOut idle", aOut, expAOut());
    else if (selBa)    cmp("R8/R2 aOut stored", aOut, expAOut());
    else               cmp("R7 aOut live", aOut, expAOut());
  endtask

  // Inputs change 3.5 ns after a clkAb edge; clock edges fall on whole ns
  task automatic stepTo();
    @(posedge clkAb);
    #3.5;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (4) stepTo();
    #1;
    checkAll();  // R9 outputs quiet during reset
    rst = 1'b0;
    // R9: both registers cleared; show them on the stored paths
    outEnN = 1'b0; dirSel = 1'b1; selAb = 1'b1; aIn = 8'hFF;
    #1;
    cmp("R9 cleared A-to-B reg", bOut, 8'h00);
    dirSel = 1'b0; selBa = 1'b1; bIn = 8'hEE;
    #1;
    cmp("R9 cleared B-to-A reg", aOut, 8'h00);

    // R3 + R1: load during isolation, replay later
    stepTo();
    outEnN = 1'b1; aIn = 8'hA5; bIn = 8'h5A;
    #1;
    cmp("R3 aOe isolated", aOe, '0);
    cmp("R3 bOe isolated", bOe, '0);
    cmp("R11 bOut isolated", bOut, '0);
    stepTo();  // A-to-B reg now holds A5
    repeat (2) @(posedge clkBa);  // B-to-A reg now holds 5A
    stepTo();
    aIn = 8'h3C; bIn = 8'hC3;
    outEnN = 1'b0; dirSel = 1'b1; selAb = 1'b1;
    #1;
    cmp("R1/R6 isolation load replayed", bOut, 8'hA5);
    cmp("R4 aOe off while B drives", aOe, '0);
    selAb = 1'b0;
    #1;
    cmp("R5 live A to B", bOut, 8'h3C);
    dirSel = 1'b0; selBa = 1'b1;
    #1;
    cmp("R2/R8 isolation load replayed", aOut, 8'h5A);
    cmp("R4 bOe off while A drives", bOe, '0);
    selBa = 1'b0;
    #1;
    cmp("R7 live B to A", aOut, 8'hC3);

    // Random mix of all modes, short resets and loads
    for (int i = 0; i < 1500; i++) begin
      stepTo();
      rst    = ($urandom % 40) == 0;
      outEnN = ($urandom % 4) == 0;
      dirSel = $urandom % 2;
      selAb  = $urandom % 2;
      selBa  = $urandom % 2;
      aIn    = W'($urandom);
      bIn    = W'($urandom);
      #1;
      checkAll();
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        #(200000 * 20);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule